// File: doc/BRIEF.md
# Timed Two-Lane Virtual-Channel Arbiter

This block sits at one input port of a router whose port carries two virtual-channel lanes, each with its own input buffer. It decides which lane may present its head flit to the downstream flow control unit. Each buffer reports whether it is empty. The downstream unit answers a pending request with a grant pulse. A later pulse marks the moment the tail flit of that packet has left.

The arbiter has three states: idle, lane 0 granted and lane 1 granted. A lane that has been granted but has not yet received a downstream grant is timed. When its wait window runs out and the opposite lane holds a flit, the grant moves to the opposite lane. A header blocked on one lane therefore cannot starve a header on the other lane of the same port. Once the downstream grant arrives, the lane is locked until its tail has gone, so a packet is never split. The length of the wait window is a run-time input.

Top module: `vc_lane_arbiter`

## Requirements
- R1: After reset, `lane_gnt` is 2'b00 and `req_valid` is 0, and both stay that way while both `lane_empty` bits are 1.
- R2: From idle, a lane whose `lane_empty` bit is 0 is granted at the next clock edge. `lane_gnt` bit i stands for lane i. When both lanes are non-empty in the same cycle, lane 0 (2'b01) wins.
- R3: `req_valid` is high for exactly one cycle, the first cycle of each new grant tenure. This covers entry from idle, a hand-over to the other lane, and a new packet on the same lane after a release. It is never high without a grant.
- R4: A granted, unlocked lane that receives no `fcu_grant` holds the grant for exactly `wait_limit` cycles. If the other lane is non-empty at that point, the grant moves to the other lane. Under continued blocking the two lanes therefore alternate.
- R5: When the wait window of the granted lane expires and the other lane is empty, the grant stays on the same lane, a fresh window starts and `req_valid` stays low.
- R6: `fcu_grant` sampled high in an unlocked grant state locks the lane. The grant is then held, with no timeout, until `tail_done`. `fcu_grant` has no effect while idle or already locked.
- R7: On `tail_done` in a locked state, the grant goes to the other lane if that lane is non-empty. Otherwise it starts a new tenure on the same lane if that lane is still non-empty. Otherwise the arbiter returns to idle.
- R8: If the granted, unlocked lane becomes empty, the grant moves at the next edge to the other lane if that lane is non-empty, and otherwise the arbiter returns to idle.
- R9: The two `lane_gnt` bits are never high together, and `wait_limit` must never be 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_empty | input | 2 | Bit i high when the buffer of lane i holds no flit |
| fcu_grant | input | 1 | Downstream unit accepted the pending request |
| tail_done | input | 1 | Tail flit of the locked packet has left |
| wait_limit | input | CNT_W | Wait window length in cycles, non-zero |
| lane_gnt | output | 2 | One-hot grant, bit i for lane i |
| req_valid | output | 1 | One-cycle strobe at the start of each grant tenure |

## Verification
The hardest situation to reach from the ports is a timeout that finds the other lane empty, so that the window restarts on the same lane, followed directly by a lock taken late in that second window. The stimulus keeps only lane 0 occupied through a full window, checks that neither the grant nor the strobe moves, and then raises `fcu_grant`. It then keeps both lanes occupied for longer than the window to show that the lock suppresses the timer. A second run changes `wait_limit` between packets while idle and measures the new hold length from the hand-over strobe.

// File: rtl/vca_pkg.sv
package vca_pkg;

  localparam int unsigned VCA_CNT_MAX_W = 16;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_LANE0 = 2'd1,
    ARB_LANE1 = 2'd2
  } arb_state_e;

  // Wait window ends in the cycle whose count is one below the limit.
  function automatic logic window_done(input logic [VCA_CNT_MAX_W-1:0] cnt,
                                       input logic [VCA_CNT_MAX_W-1:0] lim);
    return ({1'b0, cnt} + 17'd1) >= {1'b0, lim};
  endfunction

  function automatic logic [1:0] lane_onehot(input arb_state_e s);
    case (s)
      ARB_LANE0: return 2'b01;
      ARB_LANE1: return 2'b10;
      default:   return 2'b00;
    endcase
  endfunction

  function automatic arb_state_e opposite(input arb_state_e s);
    return (s == ARB_LANE1) ? ARB_LANE0 : ARB_LANE1;
  endfunction

endpackage

// File: rtl/vca_req_decode.sv
module vca_req_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic [LANES-1:0] lane_empty,
  output logic [LANES-1:0] lane_req
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_req[i] = ~lane_empty[i];
  end
endmodule

// File: rtl/vca_wait_timer.sv
module vca_wait_timer
  import vca_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             expired
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (run)     count <= count + ONE;
  end

  assign expired = run && window_done(VCA_CNT_MAX_W'(count), VCA_CNT_MAX_W'(limit));
endmodule

// File: rtl/vca_state_fsm.sv
module vca_state_fsm
  import vca_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lane_req,
  input  logic       fcu_grant,
  input  logic       tail_done,
  input  logic       expired,
  output arb_state_e state,
  output logic       lock_q,
  output logic       strobe_q,
  output logic       run,
  output logic       restart,
  output logic       lock_evt,
  output logic       release_evt
);
  arb_state_e nxt;
  logic       nxt_lock, start, keep, own_req, oth_req;

  always_comb begin
    nxt         = state;
    nxt_lock    = lock_q;
    start       = 1'b0;
    keep        = 1'b0;
    lock_evt    = 1'b0;
    release_evt = 1'b0;
    own_req     = (state == ARB_LANE1) ? lane_req[1] : lane_req[0];
    oth_req     = (state == ARB_LANE1) ? lane_req[0] : lane_req[1];
    case (state)
      ARB_IDLE: begin
        nxt_lock = 1'b0;
        if (lane_req[0])      begin nxt = ARB_LANE0; start = 1'b1; end
        else if (lane_req[1]) begin nxt = ARB_LANE1; start = 1'b1; end
      end
      ARB_LANE0, ARB_LANE1: begin
        if (lock_q) begin
          if (tail_done) begin
            release_evt = 1'b1;
            nxt_lock    = 1'b0;
            if (oth_req)      begin nxt = opposite(state); start = 1'b1; end
            else if (own_req) start = 1'b1;
            else              nxt = ARB_IDLE;
          end
        end else if (fcu_grant) begin
          lock_evt = 1'b1;
          nxt_lock = 1'b1;
        end else if (!own_req) begin
          if (oth_req) begin nxt = opposite(state); start = 1'b1; end
          else         nxt = ARB_IDLE;
        end else if (expired) begin
          if (oth_req) begin nxt = opposite(state); start = 1'b1; end
        end else begin
          keep = 1'b1;
        end
      end
      default: begin
        nxt      = ARB_IDLE;
        nxt_lock = 1'b0;
      end
    endcase
  end

  assign run     = (state != ARB_IDLE) && !lock_q;
  assign restart = !keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ARB_IDLE;
      lock_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      state    <= nxt;
      lock_q   <= nxt_lock;
      strobe_q <= start;
    end
  end
endmodule

// File: rtl/vc_lane_arbiter.sv
module vc_lane_arbiter
  import vca_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lane_empty,
  input  logic             fcu_grant,
  input  logic             tail_done,
  input  logic [CNT_W-1:0] wait_limit,
  output logic [1:0]       lane_gnt,
  output logic             req_valid
);
  logic [1:0]       lane_req;
  arb_state_e       state;
  logic             lock_q, strobe_q, run, restart, lock_evt, release_evt;
  logic             expire_evt;
  logic [CNT_W-1:0] wait_count;

  vca_req_decode #(.LANES(2)) u_decode (
    .lane_empty(lane_empty),
    .lane_req  (lane_req)
  );

  vca_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .restart(restart),
    .limit  (wait_limit),
    .count  (wait_count),
    .expired(expire_evt)
  );

  vca_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_req   (lane_req),
    .fcu_grant  (fcu_grant),
    .tail_done  (tail_done),
    .expired    (expire_evt),
    .state      (state),
    .lock_q     (lock_q),
    .strobe_q   (strobe_q),
    .run        (run),
    .restart    (restart),
    .lock_evt   (lock_evt),
    .release_evt(release_evt)
  );

  assign lane_gnt  = lane_onehot(state);
  assign req_valid = strobe_q;
endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       lane_empty,
  input logic             fcu_grant,
  input logic             tail_done,
  input logic [CNT_W-1:0] wait_limit,
  input logic [1:0]       lane_gnt,
  input logic             req_valid,
  input logic             lock_q,
  input logic             expire_evt,
  input logic [CNT_W-1:0] wait_count
);
  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_gnt != 2'b11);

  // R9
  limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_limit != '0);

  // R3
  strobe_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (lane_gnt != 2'b00));

  // R2
  idle_pick_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_gnt == 2'b00 && lane_empty == 2'b00) |=> (lane_gnt == 2'b01));

  // R4
  timeout_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !fcu_grant && lane_gnt != 2'b00 && lane_empty == 2'b00)
      |=> (lane_gnt == {$past(lane_gnt[0]), $past(lane_gnt[1])}));

  // R4
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_gnt != 2'b00 && !lock_q) |-> (wait_count < wait_limit));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !tail_done) |=> ($stable(lane_gnt) && lock_q && !req_valid));

  // R8
  idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && lane_gnt != 2'b00 && lane_empty == 2'b11 && !fcu_grant)
      |=> (lane_gnt == 2'b00));
endmodule

bind vc_lane_arbiter vca_checker #(.CNT_W(CNT_W)) u_vca_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_empty(lane_empty),
  .fcu_grant (fcu_grant),
  .tail_done (tail_done),
  .wait_limit(wait_limit),
  .lane_gnt  (lane_gnt),
  .req_valid (req_valid),
  .lock_q    (lock_q),
  .expire_evt(expire_evt),
  .wait_count(wait_count)
);

// File: tb/vc_lane_arbiter_bench.sv
module vc_lane_arbiter_bench;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       lane_empty = 2'b11;
  logic             fcu_grant = 1'b0;
  logic             tail_done = 1'b0;
  logic [CNT_W-1:0] wait_limit = 8'd3;
  logic [1:0]       lane_gnt;
  logic             req_valid;

  int checks = 0;
  int fails  = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  vc_lane_arbiter #(.CNT_W(CNT_W)) u_vc_lane_arbiter (
    .clk(clk), .rst_n(rst_n), .lane_empty(lane_empty), .fcu_grant(fcu_grant),
    .tail_done(tail_done), .wait_limit(wait_limit),
    .lane_gnt(lane_gnt), .req_valid(req_valid)
  );

  // Monitor: one expected item per clock edge, compared after the edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({lane_gnt, req_valid} !== e) begin
        fails++;
        $display("FAIL %s: gnt=%b req=%b expected gnt=%b req=%b",
                 t, lane_gnt, req_valid, e[2:1], e[0]);
      end
      checks++;
      if (lane_gnt === 2'b11) begin
        fails++;
        $display("FAIL R9: gnt=%b expected at most one bit", lane_gnt);
      end
    end
  end

  // Driver: set inputs for one edge and push the outputs expected after it.
  task automatic step(input logic [1:0] emp, input logic fg, input logic td,
                      input logic [1:0] gnt, input logic rq, input string tag);
    @(negedge clk);
    lane_empty = emp;
    fcu_grant  = fg;
    tail_done  = td;
    exp_q.push_back({gnt, rq});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (lane_gnt !== 2'b00 || req_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: gnt=%b req=%b expected gnt=00 req=0", lane_gnt, req_valid);
    end
    rst_n = 1'b1;
    step(2'b11, 0, 0, 2'b00, 0, "R1 idle");
    step(2'b11, 0, 0, 2'b00, 0, "R1 idle");
    // R2: lane 0 only
    step(2'b10, 0, 0, 2'b01, 1, "R2 enter lane0");
    // R4: both waiting, limit 3
    step(2'b00, 0, 0, 2'b01, 0, "R4 hold");
    step(2'b00, 0, 0, 2'b01, 0, "R4 hold");
    step(2'b00, 0, 0, 2'b10, 1, "R4 swap to lane1");
    step(2'b00, 0, 0, 2'b10, 0, "R4 hold");
    step(2'b00, 0, 0, 2'b10, 0, "R4 hold");
    step(2'b00, 0, 0, 2'b01, 1, "R4 swap back to lane0");
    // R5: only lane 0 occupied, window expires in place
    step(2'b10, 0, 0, 2'b01, 0, "R5 hold");
    step(2'b10, 0, 0, 2'b01, 0, "R5 hold");
    step(2'b10, 0, 0, 2'b01, 0, "R5 expire stays");
    step(2'b10, 0, 0, 2'b01, 0, "R5 new window");
    // R6: lock, then blocking longer than the window
    step(2'b00, 1, 0, 2'b01, 0, "R6 lock");
    for (int i = 0; i < 5; i++) step(2'b00, (i == 2), 0, 2'b01, 0, "R6 locked hold");
    // R7: release with other lane waiting
    step(2'b00, 0, 1, 2'b10, 1, "R7 release to other");
    step(2'b00, 1, 0, 2'b10, 0, "R6 lock lane1");
    step(2'b01, 0, 1, 2'b10, 1, "R7 release same lane");
    step(2'b01, 1, 0, 2'b10, 0, "R6 lock lane1");
    step(2'b11, 0, 1, 2'b00, 0, "R7 release to idle");
    // R8: granted lane drains
    step(2'b00, 0, 0, 2'b01, 1, "R2 both, lane0 wins");
    step(2'b01, 0, 0, 2'b10, 1, "R8 drain to other");
    step(2'b11, 0, 0, 2'b00, 0, "R8 drain to idle");
    // R6: grant while idle ignored, window still runs
    step(2'b11, 1, 0, 2'b00, 0, "R6 idle grant ignored");
    step(2'b01, 0, 0, 2'b10, 1, "R2 enter lane1");
    step(2'b00, 0, 0, 2'b10, 0, "R6 hold");
    step(2'b00, 0, 0, 2'b10, 0, "R6 hold");
    step(2'b00, 0, 0, 2'b01, 1, "R6 unlocked swap");
    step(2'b11, 0, 0, 2'b00, 0, "R8 idle");
    // R4: new window length 5
    @(negedge clk);
    wait_limit = 8'd5;
    step(2'b00, 0, 0, 2'b01, 1, "R2 enter lane0");
    for (int i = 0; i < 4; i++) step(2'b00, 0, 0, 2'b01, 0, "R4 hold limit5");
    step(2'b00, 0, 0, 2'b10, 1, "R4 swap limit5");
    step(2'b11, 0, 0, 2'b00, 0, "R8 idle");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule